// File: doc/BRIEF.md
# Serial PHY Management Frame Target

This block is the device side of a bit-banged PHY management link. Software toggles a 32-bit control word. Two exact patterns of that word are strobes. A shift strobe hands one host bit to a frame decoder. A sample strobe moves one bit of prepared read data into a readable bit of the same word. The decoder recognises read and write frames. Each frame carries a 5-bit PHY address and a 5-bit register address. Together these select one entry of a 32 by 32 array of 16-bit registers.

A read frame loads the addressed value into a 32-bit output shifter. The value sits behind one dummy leading zero, so the host's first sample is a placeholder. The next sixteen samples are the data, most significant bit first. A write frame needs a turnaround pair and sixteen data bits, and then it stores the value. Register 1 is special: a read of it always returns a link indication taken from an input pin, not the stored value. The preamble is not counted, and any unexpected bit sends the decoder back to idle.

Top module: `mdio_mgmt_target`

## Requirements
- R1: After reset the control word reads 0x00000000, the decoder is idle and every register of every PHY address holds 0x0000.
- R2: Every control write stores the full 32-bit word, with one exception: on a sample strobe, bit 19 of the stored word takes the bit popped from the output shifter.
- R3: A shift strobe is a control write whose value, with bit 17 ignored, equals 0x00012000 (bits 16 and 13). The host bit it delivers is bit 17.
- R4: A sample strobe is a control write whose value, with bit 17 ignored, equals 0x00054000 (bits 18, 16 and 14). It copies bit 31 of the output shifter into control bit 19 and shifts the shifter left by one, filling with 0.
- R5: In idle, a host 1 keeps the decoder idle and a 0 advances it. The bit after that 0 must be 1, otherwise the decoder returns to idle.
- R6: The next two bits are the opcode: 1 then 0 selects read, 0 then 1 selects write, and 00 or 11 returns the decoder to idle.
- R7: Five PHY address bits and then five register address bits follow, each field MSB first. Distinct addresses reach distinct registers, including PHY 31 register 31.
- R8: When a read frame's last address bit arrives, the shifter is loaded so that the first sample gives 0 and the next sixteen give the register value MSB first. Later samples give 0, and the decoder returns to idle.
- R9: After a write frame's addresses, the decoder requires 1 then 0. Any other pair returns it to idle and leaves the target register unchanged.
- R10: A write frame's sixteen data bits arrive MSB first. After the last one the value is stored in the addressed register and the decoder returns to idle.
- R11: A read of register 1, at any PHY address, returns 0x0004 while linkUp is 1 and 0x0000 while it is 0, whatever value was written there.
- R12: A control write that matches neither strobe pattern leaves the decoder state and the output shifter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write enable |
| ctrlWrData | input | 32 | Control word value being written |
| linkUp | input | 1 | Link present indication reported through register 1 |
| ctrlValue | output | 32 | Current stored control word, bit 19 carrying the sampled read bit |

## Verification
Every result is due one clock edge after the control write that causes it. The stored control word and a popped bit in bit 19 appear on that edge. The read shifter is loaded on the edge of the final register address bit, so the first sample strobe after it already sees the dummy zero. The driver applies each write at a falling edge. A monitor notes at the following rising edge whether that write was a sample strobe. At the next falling edge it compares bit 19 with the head of the expected-bit queue, so each comparison falls exactly one edge after its stimulus. Word-level checks, such as the ignored-word and capture cases, are read at the falling edge that ends the write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int CTRL_W = 32;
  localparam int TX_BIT_POS = 17;
  localparam int RX_BIT_POS = 19;
  localparam logic [CTRL_W-1:0] TX_BIT_MASK = 32'h0002_0000;
  localparam logic [CTRL_W-1:0] SHIFT_PATTERN = 32'h0001_2000;
  localparam logic [CTRL_W-1:0] SAMPLE_PATTERN = 32'h0005_4000;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GOT_ZERO,
    ST_ATTN,
    ST_OP_HI,
    ST_OP_LO,
    ST_PHY,
    ST_REG,
    ST_TA_ONE,
    ST_TA_ZERO,
    ST_DATA
  } decState_t;

  typedef struct packed {
    logic inBit;
    logic clearFields;
    logic shiftPhy;
    logic shiftReg;
    logic shiftData;
    logic loadOut;
    logic popOut;
    logic commitWrite;
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output mdioStrobe_t       stb,
  output decState_t         decState
);

  localparam int ADDR_MAX = (PHY_AW > REG_AW) ? PHY_AW : REG_AW;
  localparam int LONGEST  = (DATA_W > ADDR_MAX) ? DATA_W : ADDR_MAX;
  localparam int CNT_W    = (LONGEST > 2) ? $clog2(LONGEST) : 1;

  logic             shiftHit;
  logic             sampleHit;
  logic             hostBit;
  decState_t        stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitCntNext;
  logic             isWrite;
  logic             isWriteNext;

  // Strobe decode: bit 17 is the host data bit and is excluded from the match
  always_comb begin
    shiftHit  = ctrlWrEn && ((ctrlWrData & ~TX_BIT_MASK) == SHIFT_PATTERN);
    sampleHit = ctrlWrEn && ((ctrlWrData & ~TX_BIT_MASK) == SAMPLE_PATTERN);
    hostBit   = ctrlWrData[TX_BIT_POS];
  end

  always_comb begin
    stb         = '0;
    stb.inBit   = hostBit;
    stb.popOut  = sampleHit;
    stateNext   = decState;
    bitCntNext  = bitCnt;
    isWriteNext = isWrite;
    if (shiftHit) begin
      unique case (decState)
        ST_IDLE: begin
          stb.clearFields = 1'b1;
          stateNext = hostBit ? ST_IDLE : ST_GOT_ZERO;
        end
        ST_GOT_ZERO: stateNext = hostBit ? ST_ATTN : ST_IDLE;
        ST_ATTN:     stateNext = hostBit ? ST_OP_HI : ST_OP_LO;
        ST_OP_HI: begin
          if (!hostBit) begin
            isWriteNext = 1'b0;
            stateNext   = ST_PHY;
            bitCntNext  = CNT_W'(PHY_AW - 1);
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_OP_LO: begin
          if (hostBit) begin
            isWriteNext = 1'b1;
            stateNext   = ST_PHY;
            bitCntNext  = CNT_W'(PHY_AW - 1);
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_PHY: begin
          stb.shiftPhy = 1'b1;
          if (bitCnt == '0) begin
            stateNext  = ST_REG;
            bitCntNext = CNT_W'(REG_AW - 1);
          end else begin
            bitCntNext = bitCnt - 1'b1;
          end
        end
        ST_REG: begin
          stb.shiftReg = 1'b1;
          if (bitCnt == '0) begin
            if (isWrite) begin
              stateNext = ST_TA_ONE;
            end else begin
              stb.loadOut = 1'b1;
              stateNext   = ST_IDLE;
            end
          end else begin
            bitCntNext = bitCnt - 1'b1;
          end
        end
        ST_TA_ONE: stateNext = hostBit ? ST_TA_ZERO : ST_IDLE;
        ST_TA_ZERO: begin
          if (!hostBit) begin
            stateNext  = ST_DATA;
            bitCntNext = CNT_W'(DATA_W - 1);
          end else begin
            stateNext = ST_IDLE;
          end
        end
        ST_DATA: begin
          stb.shiftData = 1'b1;
          if (bitCnt == '0) begin
            stb.commitWrite = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            bitCntNext = bitCnt - 1'b1;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      decState <= ST_IDLE;
      bitCnt   <= '0;
      isWrite  <= 1'b0;
    end else begin
      decState <= stateNext;
      bitCnt   <= bitCntNext;
      isWrite  <= isWriteNext;
    end
  end

endmodule

// File: rtl/mdio_reg_array.sv
module mdio_reg_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '0;
      end
    end else if (wrEn) begin
      cells[wrAddr] <= wrData;
    end
  end

  assign rdData = cells[rdAddr];

endmodule

// File: rtl/mdio_frame_datapath.sv
module mdio_frame_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int              PHY_AW     = 5,
  parameter int              REG_AW     = 5,
  parameter int              DATA_W     = 16,
  parameter int              STATUS_REG = 1,
  parameter logic [DATA_W-1:0] LINK_UP_VALUE = 16'h0004
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWrEn,
  input  logic [CTRL_W-1:0]   ctrlWrData,
  input  logic                linkUp,
  input  mdioStrobe_t         stb,
  output logic [CTRL_W-1:0]   ctrlValue,
  output logic [2*DATA_W-1:0] outShift
);

  localparam int OUT_W  = 2 * DATA_W;
  localparam int ADDR_W = PHY_AW + REG_AW;

  logic [PHY_AW-1:0] phyAddr;
  logic [REG_AW-1:0] regAddr;
  logic [DATA_W-1:0] dataSr;
  logic [REG_AW-1:0] regNext;
  logic [DATA_W-1:0] cellRd;
  logic [DATA_W-1:0] readVal;
  logic [DATA_W-1:0] commitVal;

  // The last address bit is still on the input when the read is served
  assign regNext   = {regAddr[REG_AW-2:0], stb.inBit};
  assign commitVal = {dataSr[DATA_W-2:0], stb.inBit};

  mdio_reg_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (stb.commitWrite),
    .wrAddr({phyAddr, regAddr}),
    .wrData(commitVal),
    .rdAddr({phyAddr, regNext}),
    .rdData(cellRd)
  );

  always_comb begin
    if (regNext == REG_AW'(STATUS_REG)) begin
      readVal = linkUp ? LINK_UP_VALUE : '0;
    end else begin
      readVal = cellRd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyAddr <= '0;
      regAddr <= '0;
      dataSr  <= '0;
    end else if (stb.clearFields) begin
      phyAddr <= '0;
      regAddr <= '0;
      dataSr  <= '0;
    end else begin
      if (stb.shiftPhy)  phyAddr <= {phyAddr[PHY_AW-2:0], stb.inBit};
      if (stb.shiftReg)  regAddr <= regNext;
      if (stb.shiftData) dataSr  <= commitVal;
    end
  end

  // Output shifter: one dummy zero ahead of the value, then zeros behind it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outShift <= '0;
    end else if (stb.loadOut) begin
      outShift <= {1'b0, readVal, {(DATA_W-1){1'b0}}};
    end else if (stb.popOut) begin
      outShift <= {outShift[OUT_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlValue <= '0;
    end else if (ctrlWrEn) begin
      ctrlValue <= ctrlWrData;
      if (stb.popOut) begin
        ctrlValue[RX_BIT_POS] <= outShift[OUT_W-1];
      end
    end
  end

endmodule

// File: rtl/mdio_mgmt_target.sv
module mdio_mgmt_target
  import mdio_mgmt_pkg::*;
#(
  parameter int              PHY_AW     = 5,
  parameter int              REG_AW     = 5,
  parameter int              DATA_W     = 16,
  parameter int              STATUS_REG = 1,
  parameter logic [DATA_W-1:0] LINK_UP_VALUE = 16'h0004
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWrEn,
  input  logic [31:0] ctrlWrData,
  input  logic        linkUp,
  output logic [31:0] ctrlValue
);

  localparam int OUT_W = 2 * DATA_W;

  mdioStrobe_t      stb;
  decState_t        decState;
  logic [OUT_W-1:0] outShift;

  mdio_frame_ctrl #(
    .PHY_AW(PHY_AW),
    .REG_AW(REG_AW),
    .DATA_W(DATA_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .stb       (stb),
    .decState  (decState)
  );

  mdio_frame_datapath #(
    .PHY_AW       (PHY_AW),
    .REG_AW       (REG_AW),
    .DATA_W       (DATA_W),
    .STATUS_REG   (STATUS_REG),
    .LINK_UP_VALUE(LINK_UP_VALUE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .linkUp    (linkUp),
    .stb       (stb),
    .ctrlValue (ctrlValue),
    .outShift  (outShift)
  );

endmodule

// File: rtl/mdio_mgmt_target_chk.sv
module mdio_mgmt_target_chk
  import mdio_mgmt_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctrlWrEn,
  input logic [31:0]      ctrlWrData,
  input logic [31:0]      ctrlValue,
  input decState_t        decState,
  input logic [OUT_W-1:0] outShift
);

  logic isShift;
  logic isSample;
  logic hBit;

  assign isShift  = ctrlWrEn && ((ctrlWrData & 32'hFFFD_FFFF) == 32'h0001_2000);
  assign isSample = ctrlWrEn && ((ctrlWrData & 32'hFFFD_FFFF) == 32'h0005_4000);
  assign hBit     = ctrlWrData[17];

  AST_CAPTURE_WORD: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrEn |=> (ctrlValue[18:0] == $past(ctrlWrData[18:0])) &&
                 (ctrlValue[31:20] == $past(ctrlWrData[31:20]))); // R2

  AST_POP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    isSample |=> ctrlValue[19] == $past(outShift[OUT_W-1])); // R4

  AST_POP_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    isSample |=> outShift == {$past(outShift[OUT_W-2:0]), 1'b0}); // R4

  AST_IDLE_ON_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && decState == ST_IDLE && hBit) |=> decState == ST_IDLE); // R5

  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && decState == ST_GOT_ZERO && !hBit) |=> decState == ST_IDLE); // R5

  AST_OPCODE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && ((decState == ST_OP_HI && hBit) || (decState == ST_OP_LO && !hBit)))
      |=> decState == ST_IDLE); // R6

  AST_TURN_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (isShift && ((decState == ST_TA_ONE && !hBit) || (decState == ST_TA_ZERO && hBit)))
      |=> decState == ST_IDLE); // R9

  AST_IGNORED_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !isShift && !isSample) |=> $stable(decState) && $stable(outShift)); // R12

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(ctrlValue) && $stable(decState) && $stable(outShift)); // R12

endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk #(.OUT_W(2 * DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ctrlWrEn  (ctrlWrEn),
  .ctrlWrData(ctrlWrData),
  .ctrlValue (ctrlValue),
  .decState  (decState),
  .outShift  (outShift)
);

// File: tb/mdio_mgmt_target_bench.sv
module mdio_mgmt_target_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0;
  logic        linkUp = 1'b0;
  logic [31:0] ctrlValue;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic sawPop = 1'b0;

  logic  expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  mdio_mgmt_target u_mdio_mgmt_target (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrData(ctrlWrData),
    .linkUp    (linkUp),
    .ctrlValue (ctrlValue)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      summary();
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: a sample strobe seen at a rising edge is compared at the next falling edge
  always @(posedge clk)
    sawPop <= ctrlWrEn && ((ctrlWrData & 32'hFFFD_FFFF) == 32'h0005_4000);

  always @(negedge clk) begin
    if (sawPop) begin
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R4: actual=unexpected sample expected=none");
      end else begin
        logic  e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk({31'b0, ctrlValue[19]}, {31'b0, e}, t);
      end
    end
  end

  task automatic ctrlWrite(input logic [31:0] w);
    @(negedge clk);
    ctrlWrEn = 1'b1;
    ctrlWrData = w;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    ctrlWrite(32'h0001_2000 | (32'(b) << 17));
  endtask

  task automatic sendBits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sendBit(v[i]);
  endtask

  task automatic writeFrame(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] val, input logic [1:0] ta, input int pre);
    sendBits(32'hFFFF_FFFF, pre);
    sendBits(32'b0101, 4);
    sendBits({27'b0, phy}, 5);
    sendBits({27'b0, rg}, 5);
    sendBits({30'b0, ta}, 2);
    sendBits({16'b0, val}, 16);
  endtask

  task automatic readFrame(input logic [4:0] phy, input logic [4:0] rg);
    sendBits(32'hF, 4);
    sendBits(32'b0110, 4);
    sendBits({27'b0, phy}, 5);
    sendBits({27'b0, rg}, 5);
  endtask

  task automatic popExpect(input logic e, input string tag, input logic txSet);
    expQ.push_back(e);
    tagQ.push_back(tag);
    ctrlWrite(txSet ? 32'h0007_4000 : 32'h0005_4000);
  endtask

  task automatic readExpect(input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] val, input string tag);
    readFrame(phy, rg);
    popExpect(1'b0, {tag, " dummy lead R8"}, 1'b0);
    for (int i = 15; i >= 0; i--) popExpect(val[i], tag, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(ctrlValue, 32'h0, "R1 control word in reset");
    rstN = 1'b1;
    @(negedge clk);
    chk(ctrlValue, 32'h0, "R1 control word after reset");
    readExpect(5'd3, 5'd5, 16'h0000, "R1 register cleared");
    readExpect(5'd31, 5'd30, 16'h0000, "R1 register cleared");

    // Basic write and read back, distinct addresses
    writeFrame(5'd3, 5'd5, 16'hA5C3, 2'b10, 4);
    readExpect(5'd3, 5'd5, 16'hA5C3, "R10 stored value");
    popExpect(1'b0, "R8 trailing zero", 1'b0);
    popExpect(1'b0, "R8 trailing zero", 1'b0);
    writeFrame(5'd12, 5'd5, 16'h1234, 2'b10, 2);
    readExpect(5'd12, 5'd5, 16'h1234, "R7 other phy");
    readExpect(5'd3, 5'd5, 16'hA5C3, "R7 first phy kept");
    writeFrame(5'd31, 5'd31, 16'hFFFF, 2'b10, 1);
    readExpect(5'd31, 5'd31, 16'hFFFF, "R7 top address");
    writeFrame(5'd0, 5'd0, 16'h8001, 2'b10, 0);
    readExpect(5'd0, 5'd0, 16'h8001, "R10 msb and lsb");

    // Link status register
    writeFrame(5'd2, 5'd1, 16'hFFFF, 2'b10, 2);
    linkUp = 1'b1;
    readExpect(5'd2, 5'd1, 16'h0004, "R11 link up");
    readExpect(5'd9, 5'd1, 16'h0004, "R11 link up other phy");
    linkUp = 1'b0;
    readExpect(5'd2, 5'd1, 16'h0000, "R11 link down");

    // Aborted starts and opcodes, each followed at once by a valid frame
    sendBits(32'b00, 2);
    writeFrame(5'd4, 5'd7, 16'h0F0F, 2'b10, 0);
    readExpect(5'd4, 5'd7, 16'h0F0F, "R5 restart after 00");
    sendBits(32'b0100, 4);
    writeFrame(5'd4, 5'd8, 16'h3C3C, 2'b10, 0);
    readExpect(5'd4, 5'd8, 16'h3C3C, "R6 opcode 00 aborts");
    sendBits(32'b0111, 4);
    writeFrame(5'd4, 5'd9, 16'h5AA5, 2'b10, 0);
    readExpect(5'd4, 5'd9, 16'h5AA5, "R6 opcode 11 aborts");

    // Bad turnaround leaves register unchanged
    writeFrame(5'd6, 5'd9, 16'h1111, 2'b10, 2);
    writeFrame(5'd6, 5'd9, 16'hFFFF, 2'b00, 2);
    writeFrame(5'd6, 5'd9, 16'hFFFF, 2'b11, 2);
    readExpect(5'd6, 5'd9, 16'h1111, "R9 bad turnaround");

    // Non-matching control words in mid frame
    sendBits(32'hF, 4);
    sendBits(32'b0101, 4);
    sendBits(32'd10, 5);
    ctrlWrite(32'h0001_2001);
    chk(ctrlValue, 32'h0001_2001, "R2 plain word stored");
    ctrlWrite(32'h0001_0000);
    ctrlWrite(32'h0005_2000);
    sendBits(32'd20, 5);
    sendBits(32'b10, 2);
    sendBits(32'hC3A5, 16);
    readFrame(5'd10, 5'd20);
    popExpect(1'b0, "R8 dummy lead", 1'b0);
    popExpect(1'b1, "R3 tx bit data", 1'b1);
    chk(ctrlValue, 32'h000F_4000, "R2 bit 19 from sample");
    popExpect(1'b1, "R4 sample with tx bit", 1'b1);
    ctrlWrite(32'h0005_4001);
    chk(ctrlValue, 32'h0005_4001, "R12 ignored word stored");
    ctrlWrite(32'h0001_4000);
    for (int i = 13; i >= 0; i--) popExpect(((16'hC3A5 >> i) & 16'h1) != 0, "R12 shifter held", 1'b0);

    repeat (3) @(negedge clk);
    chk(32'(expQ.size()), 32'h0, "R4 all samples observed");
    summary();
  end

endmodule